// File: doc/BRIEF.md
# Shared Work-RAM Ownership Controller

This block holds the control byte and the write-protect byte that decide who may use a work RAM shared by a main processor and a sub processor. Each processor has its own byte-wide write port and its own 16-bit read port. One select bit on each write port picks the control byte or the write-protect byte.

The RAM runs in one of two layouts. In whole layout, one side owns all of it. In split layout, each side sees one of two half-banks. Ownership moves through a request/return handshake. The main side requests with a request bit. The sub side hands the RAM over with a return bit.

The block drives the ownership signals for the memory fabric that sits around it. It also drives a one-cycle remap pulse, so that the fabric can redo its address mapping after any change of owner or layout.

Top module: `ram_own_ctrl`

## Requirements
- R1: After reset, the control byte is 0x01 (return=1, request=0, whole layout, priority 0, program bank 0) and the write-protect byte is 0x00. The main side owns the RAM (`wholeOwnerSub`=0) and `remapStrobe` is 0.
- R2: A main write with sel=1 changes only control bits 7:6 (program bank) and bit 1 (request). A main write with sel=0 loads the write-protect byte. `mainRdData` is {write-protect, control & 0xC7}. `subRdData` is {write-protect, control & 0x1F}. Bit 5 of the control byte always reads 0.
- R3: A sub write with sel=1 changes only control bits 0 (return), 2 (layout, 1 = split) and 4:3 (priority), apart from the request-bit rules below. A sub write with sel=0 has no effect on the write-protect byte.
- R4: In split layout, a main write with bit 1 = 0 sets the request bit. A main write with bit 1 = 1 leaves the request bit unchanged.
- R5: In whole layout, a main write that raises the request bit from 0 to 1 clears the return bit, which gives the RAM to the sub side. A main write with bit 1 = 0 clears the request bit.
- R6: In whole layout (before and after the write), the sub side can only set the return bit, and writing 0 leaves it as it was. While the return bit is 1 after a sub write, the request bit is 0.
- R7: A sub write that leaves the block in split layout and changes the layout bit or the return bit clears the request bit. A sub write that changes neither keeps the request bit.
- R8: When a sub write moves the block from split to whole layout with bit 0 = 0, the RAM goes to the side that held half-bank 0. If the old return bit was 1, the result is request=1 and return=0. Otherwise the result is return=1 and request=0.
- R9: In split layout, `mainHalf` equals the return bit and `subHalf` is the other half-bank. In whole layout, `wholeOwnerSub` is the inverse of the return bit.
- R10: `remapStrobe` is high for exactly the one cycle after a write that changes the layout bit or the return bit. It stays low after writes that change neither.
- R11: When both sides write the control byte in the same cycle, the main write is applied first and the sub write is applied to its result. When both sides write the write-protect select in the same cycle, the main value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mainWrEn | input | 1 | Main-side byte write enable |
| mainWrSel | input | 1 | 1 = control byte, 0 = write-protect byte |
| mainWrData | input | 8 | Main-side write data |
| mainRdData | output | 16 | {write-protect, control & 0xC7} |
| subWrEn | input | 1 | Sub-side byte write enable |
| subWrSel | input | 1 | 1 = control byte, 0 = write-protect byte (ignored) |
| subWrData | input | 8 | Sub-side write data |
| subRdData | output | 16 | {write-protect, control & 0x1F} |
| splitMode | output | 1 | 1 = split layout |
| wholeOwnerSub | output | 1 | Whole layout: 1 = sub side owns the RAM |
| mainHalf | output | 1 | Half-bank the main side sees in split layout |
| subHalf | output | 1 | Half-bank the sub side sees in split layout |
| remapStrobe | output | 1 | One-cycle pulse after an ownership or layout change |

## Verification
The hardest state to reach is the return from split to whole layout with the return bit clear. The outcome depends on which half-bank each side held, so the bench has to enter split layout once with return=1 and once with return=0 before each exit.

The second hard case is a same-cycle write from both sides. The bench drives it from a state where applying the two writes in the wrong order gives a different control byte. That state is whole layout with the request bit already set, where a main write keeps request=1 and a sub write sets return.

The remaining negative cases are covered as well. These are the sub writes in split layout that keep the request bit, and the main writes of 1 that leave it unchanged. Each is followed by a check that the remap pulse stayed low.

// File: rtl/ram_own_pkg.sv
package ram_own_pkg;
  localparam int BYTE_W = 8;
  localparam int RD_W   = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] MAIN_RD_MASK = 8'hC7;
  localparam logic [BYTE_W-1:0] SUB_RD_MASK  = 8'h1F;

  typedef struct packed {
    logic [1:0] bank;
    logic       spare;
    logic [1:0] prio;
    logic       split;
    logic       req;
    logic       ret;
  } ctrlReg_t;

  localparam ctrlReg_t CTRL_RESET = '{bank: 2'd0, spare: 1'b0, prio: 2'd0,
                                      split: 1'b0, req: 1'b0, ret: 1'b1};

  typedef struct packed {
    logic mainCtrlWr;
    logic subCtrlWr;
    logic mainWpWr;
  } wrStrobe_t;
endpackage

// File: rtl/ram_own_decode.sv
module ram_own_decode
  import ram_own_pkg::*;
(
  input  logic      mainWrEn,
  input  logic      mainWrSel,
  input  logic      subWrEn,
  input  logic      subWrSel,
  output wrStrobe_t strobes
);
  always_comb begin
    strobes.mainCtrlWr = mainWrEn & mainWrSel;
    strobes.mainWpWr   = mainWrEn & ~mainWrSel;
    // sub-side writes to the protect byte are dropped here
    strobes.subCtrlWr  = subWrEn & subWrSel;
  end
endmodule

// File: rtl/ram_own_datapath.sv
module ram_own_datapath
  import ram_own_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wrStrobe_t         strobes,
  input  logic [BYTE_W-1:0] mainWrData,
  input  logic [BYTE_W-1:0] subWrData,
  output logic [RD_W-1:0]   mainRdData,
  output logic [RD_W-1:0]   subRdData,
  output logic              splitMode,
  output logic              wholeOwnerSub,
  output logic              mainHalf,
  output logic              subHalf,
  output logic              remapStrobe
);
  ctrlReg_t ctrlQ, afterMain, afterSub;
  logic [BYTE_W-1:0] wpQ;

  // main-side update: program bank and request bit only
  always_comb begin
    afterMain = ctrlQ;
    if (strobes.mainCtrlWr) begin
      afterMain.bank = mainWrData[7:6];
      if (ctrlQ.split) begin
        if (!mainWrData[1]) afterMain.req = 1'b1;
      end else begin
        afterMain.req = mainWrData[1];
        if (mainWrData[1] && !ctrlQ.req) afterMain.ret = 1'b0;
      end
    end
  end

  // sub-side update, applied on top of the main-side result
  always_comb begin
    afterSub = afterMain;
    if (strobes.subCtrlWr) begin
      afterSub.prio  = subWrData[4:3];
      afterSub.split = subWrData[2];
      if (subWrData[2]) begin
        afterSub.ret = subWrData[0];
        if ((subWrData[2] != afterMain.split) || (subWrData[0] != afterMain.ret))
          afterSub.req = 1'b0;
      end else begin
        if (afterMain.split) begin
          if (subWrData[0]) begin
            afterSub.ret = 1'b1;
          end else if (afterMain.ret) begin
            afterSub.ret = 1'b0;
            afterSub.req = 1'b1;
          end else begin
            afterSub.ret = 1'b1;
            afterSub.req = 1'b0;
          end
        end else begin
          afterSub.ret = afterMain.ret | subWrData[0];
        end
        if (afterSub.ret) afterSub.req = 1'b0;
      end
    end
    afterSub.spare = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlQ       <= CTRL_RESET;
      wpQ         <= '0;
      remapStrobe <= 1'b0;
    end else begin
      ctrlQ       <= afterSub;
      if (strobes.mainWpWr) wpQ <= mainWrData;
      remapStrobe <= (afterSub.split != ctrlQ.split) || (afterSub.ret != ctrlQ.ret);
    end
  end

  always_comb begin
    mainRdData    = {wpQ, ctrlQ & MAIN_RD_MASK};
    subRdData     = {wpQ, ctrlQ & SUB_RD_MASK};
    splitMode     = ctrlQ.split;
    wholeOwnerSub = ~ctrlQ.ret;
    mainHalf      = ctrlQ.ret;
    subHalf       = ~ctrlQ.ret;
  end
endmodule

// File: rtl/ram_own_ctrl.sv
module ram_own_ctrl
  import ram_own_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mainWrEn,
  input  logic              mainWrSel,
  input  logic [BYTE_W-1:0] mainWrData,
  output logic [RD_W-1:0]   mainRdData,
  input  logic              subWrEn,
  input  logic              subWrSel,
  input  logic [BYTE_W-1:0] subWrData,
  output logic [RD_W-1:0]   subRdData,
  output logic              splitMode,
  output logic              wholeOwnerSub,
  output logic              mainHalf,
  output logic              subHalf,
  output logic              remapStrobe
);
  wrStrobe_t strobes;

  ram_own_decode u_decode (
    .mainWrEn  (mainWrEn),
    .mainWrSel (mainWrSel),
    .subWrEn   (subWrEn),
    .subWrSel  (subWrSel),
    .strobes   (strobes)
  );

  ram_own_datapath u_data (
    .clk           (clk),
    .rst           (rst),
    .strobes       (strobes),
    .mainWrData    (mainWrData),
    .subWrData     (subWrData),
    .mainRdData    (mainRdData),
    .subRdData     (subRdData),
    .splitMode     (splitMode),
    .wholeOwnerSub (wholeOwnerSub),
    .mainHalf      (mainHalf),
    .subHalf       (subHalf),
    .remapStrobe   (remapStrobe)
  );
endmodule

// File: rtl/ram_own_ctrl_chk.sv
module ram_own_ctrl_chk
  import ram_own_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            mainWrEn,
  input logic            mainWrSel,
  input logic            subWrEn,
  input logic            subWrSel,
  input logic [RD_W-1:0] mainRdData,
  input logic [RD_W-1:0] subRdData,
  input logic            splitMode,
  input logic            mainHalf,
  input logic            subHalf,
  input logic            remapStrobe
);
  assert_main_mask_R2: assert property (@(posedge clk) disable iff (rst)
    mainRdData[5:3] == 3'b000);

  assert_sub_mask_R2: assert property (@(posedge clk) disable iff (rst)
    subRdData[7:5] == 3'b000);

  assert_sub_wp_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (subWrEn && !subWrSel && !(mainWrEn && !mainWrSel)) |=> $stable(mainRdData[15:8]));

  assert_ret_clears_req_R6: assert property (@(posedge clk) disable iff (rst)
    (!splitMode && mainRdData[0]) |-> !mainRdData[1]);

  assert_halves_differ_R9: assert property (@(posedge clk) disable iff (rst)
    splitMode |-> (mainHalf != subHalf));

  assert_strobe_on_change_R10: assert property (@(posedge clk) disable iff (rst)
    remapStrobe |-> ((splitMode != $past(splitMode)) || (mainRdData[0] != $past(mainRdData[0]))));
endmodule

bind ram_own_ctrl ram_own_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .mainWrEn    (mainWrEn),
  .mainWrSel   (mainWrSel),
  .subWrEn     (subWrEn),
  .subWrSel    (subWrSel),
  .mainRdData  (mainRdData),
  .subRdData   (subRdData),
  .splitMode   (splitMode),
  .mainHalf    (mainHalf),
  .subHalf     (subHalf),
  .remapStrobe (remapStrobe)
);

// File: tb/ram_own_ctrl_tb.sv
module ram_own_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mainWrEn = 1'b0, mainWrSel = 1'b0, subWrEn = 1'b0, subWrSel = 1'b0;
  logic [7:0] mainWrData = '0, subWrData = '0;
  logic [15:0] mainRdData, subRdData;
  logic splitMode, wholeOwnerSub, mainHalf, subHalf, remapStrobe;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  ram_own_ctrl u_dut (
    .clk(clk), .rst(rst),
    .mainWrEn(mainWrEn), .mainWrSel(mainWrSel), .mainWrData(mainWrData), .mainRdData(mainRdData),
    .subWrEn(subWrEn), .subWrSel(subWrSel), .subWrData(subWrData), .subRdData(subRdData),
    .splitMode(splitMode), .wholeOwnerSub(wholeOwnerSub),
    .mainHalf(mainHalf), .subHalf(subHalf), .remapStrobe(remapStrobe)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one write on each side (enables chosen), sample after the edge
  task automatic wr(bit mEn, bit mSel, logic [7:0] mD, bit sEn, bit sSel, logic [7:0] sD);
    @(negedge clk);
    mainWrEn = mEn; mainWrSel = mSel; mainWrData = mD;
    subWrEn = sEn;  subWrSel = sSel;  subWrData = sD;
    @(negedge clk);
    mainWrEn = 1'b0; subWrEn = 1'b0;
  endtask

  // full control check: main read low byte, sub read low byte, strobe
  task automatic ctl(string req, logic [7:0] c, bit strobe);
    chk(req, {8'h0, mainRdData[7:0]}, {8'h0, c & 8'hC7});
    chk(req, {8'h0, subRdData[7:0]},  {8'h0, c & 8'h1F});
    chk(req, {15'h0, remapStrobe}, {15'h0, strobe});
  endtask

  task automatic t_reset();
    chk("R1", mainRdData, 16'h0001);
    chk("R1", subRdData, 16'h0001);
    chk("R1", {14'h0, wholeOwnerSub, remapStrobe}, 16'h0);
  endtask

  task automatic t_wp();
    wr(1, 0, 8'h5A, 0, 0, 8'h00);
    chk("R2", mainRdData, 16'h5A01);
    wr(0, 0, 8'h00, 1, 0, 8'h33);
    chk("R3", mainRdData[15:8], 8'h5A);
    chk("R3", subRdData, 16'h5A01);
  endtask

  task automatic t_whole();
    wr(1, 1, 8'hFF, 0, 0, 8'h00);           // R5: request raised, RET cleared
    ctl("R5", 8'hC2, 1'b1);
    chk("R9", {15'h0, wholeOwnerSub}, 16'h1);
    wr(0, 0, 8'h00, 1, 1, 8'h00);           // R6: writing 0 to RET does nothing
    ctl("R6", 8'hC2, 1'b0);
    wr(0, 0, 8'h00, 1, 1, 8'h19);           // R6: RET set clears request
    ctl("R6", 8'hD9, 1'b1);
    chk("R9", {15'h0, wholeOwnerSub}, 16'h0);
  endtask

  task automatic t_split();
    wr(0, 0, 8'h00, 1, 1, 8'h05);           // enter split, RET=1
    ctl("R7", 8'hC5, 1'b1);
    chk("R9", {14'h0, mainHalf, subHalf}, 16'h2);
    wr(1, 1, 8'h02, 0, 0, 8'h00);           // R4: write 1 leaves request
    ctl("R4", 8'h05, 1'b0);
    wr(1, 1, 8'h00, 0, 0, 8'h00);           // R4: write 0 sets request
    ctl("R4", 8'h07, 1'b0);
    wr(0, 0, 8'h00, 1, 1, 8'h04);           // R7: RET change clears request
    ctl("R7", 8'h04, 1'b1);
    chk("R9", {14'h0, mainHalf, subHalf}, 16'h1);
    wr(1, 1, 8'h00, 0, 0, 8'h00);
    wr(0, 0, 8'h00, 1, 1, 8'h0C);           // R7: no mode/RET change keeps request
    ctl("R7", 8'h0E, 1'b0);
  endtask

  task automatic t_leave_split();
    wr(0, 0, 8'h00, 1, 1, 8'h00);           // R8: main held bank 0
    ctl("R8", 8'h01, 1'b1);
    chk("R8", {14'h0, splitMode, wholeOwnerSub}, 16'h0);
    wr(0, 0, 8'h00, 1, 1, 8'h05);
    ctl("R8", 8'h05, 1'b1);
    wr(0, 0, 8'h00, 1, 1, 8'h00);           // R8: sub held bank 0
    ctl("R8", 8'h02, 1'b1);
    chk("R8", {15'h0, wholeOwnerSub}, 16'h1);
  endtask

  task automatic t_both();
    wr(1, 1, 8'h82, 1, 1, 8'h01);           // R11: main first, then sub
    ctl("R11", 8'h81, 1'b1);
    wr(1, 0, 8'hA5, 1, 0, 8'h3C);
    chk("R11", mainRdData[15:8], 8'hA5);
    @(negedge clk);
    chk("R10", {15'h0, remapStrobe}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_wp();
    t_whole();
    t_split();
    t_leave_split();
    t_both();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule